// File: doc/BRIEF.md
# Serial Clock-Configuration Slave

This block is a two-wire serial slave that keeps a small bank of clock-control registers and presents them as parallel control vectors to the clock generator around it. Register 0 holds function and frequency-select bits. The other registers are output-enable masks, where a 1 lets a clock run and a 0 stops it and holds it low. The slave samples SCL and SDA with the system clock and drives SDA open-drain through a single pull-low output.

Transfers always use block framing. In a write frame, the address byte is followed by two placeholder bytes, which are acknowledged and then thrown away. The data bytes that come next fill the registers from index 0 upward. In a read frame, the slave first sends a byte count and then every register in ascending order. No register index is ever sent on the bus. A frame always starts at register 0, and a write can be cut short at any byte boundary.

While the `hold` input is high (the device is powered down), the slave ignores bus activity, releases SDA and keeps every register as it is.

Top module: `cfgbus_slave`

## Requirements
- R1: The slave acknowledges the 8-bit address bytes 0xD2 (write) and 0xD3 (read), which is 7-bit address 0x69 with the R/W bit in bit 0. Any other address is not acknowledged, and the slave then ignores the bus until the next START.
- R2: In a write frame, the two bytes after the address (command and count) are each acknowledged, and their values leave every register unchanged.
- R3: In a write frame, the data bytes after the two placeholders load register 0, then 1, and so on up to register 5. Each byte is acknowledged, and its register takes the new value on the SCL fall that ends the byte's eighth bit, before any STOP.
- R4: When a STOP ends a write after any complete byte, the registers already written keep their new values and the remaining registers are unchanged.
- R5: A read frame returns the byte count 6 first, then registers 0 to 5, each byte most significant bit first.
- R6: In a read, if the master NACKs a byte, or acknowledges register 5 and keeps clocking, the slave releases SDA (the master reads 0xFF) until the next START or STOP.
- R7: After reset, register 0 is 0x0C (bits 3 and 2 set), registers 1 to 5 are 0xFF (all outputs enabled), and SDA is released.
- R8: While `hold` is high, SDA is released, no byte is acknowledged and no register changes. `hold` takes precedence over a register update that falls due in the same cycle. After `hold` falls, the slave waits for a new START.
- R9: Write data bytes beyond register 5 are acknowledged and discarded.
- R10: The slave changes SDA only while the synchronised SCL is low, and it releases SDA within four clocks after the SCL fall that ends an acknowledge. Each SCL phase must last at least four system clocks, which any standard-mode (100 kbit/s) bus meets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold | input | 1 | Power-down hold: bus ignored, registers retained |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| func_sel | output | 8 | Register 0, function and frequency select |
| clk_enables | output | 40 | Registers 1 to 5, byte k-1 holds register k |

## Verification
A register update and a power-down hold can fall in the same cycle. This happens when `hold` rises together with the SCL fall that completes a data byte, so the write and the forced return to idle meet at one clock edge. The bench raises `hold` on the very clock where it drops SCL after the eighth bit of the register-0 byte. It then checks that this byte gets no acknowledge, that register 0 keeps its old value, and that a later read frame returns the unchanged bank.

// File: rtl/cfgbus_slave.sv
module cfgbus_slave #(
  parameter int          NREG     = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [7:0]  FUNC_RST = 8'h0C,
  parameter logic [7:0]  ENA_RST  = 8'hFF,
  parameter int          SYNC     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hold,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_pull,
  output logic [7:0]               func_sel,
  output logic [(NREG-1)*8-1:0]    clk_enables
);

  localparam int            IW         = $clog2(NREG + 4);
  localparam logic [7:0]    COUNT_BYTE = 8'(NREG);
  localparam logic [IW-1:0] IDX_CAP    = IW'(NREG + 2);
  localparam logic [IW-1:0] IDX_LAST   = IW'(NREG);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WDATA, S_ACKO, S_TX, S_ACKI, S_WAIT
  } st_t;

  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_d, sda_d;
  logic start_c, stop_c, scl_rise, scl_fall;

  st_t           state;
  logic [2:0]    bitcnt;
  logic          flag;
  logic          is_read;
  logic [7:0]    sh;
  logic [7:0]    txsh;
  logic [IW-1:0] idx;
  logic [IW-1:0] rd_idx;
  logic [7:0]    tx_next;
  logic          wr_en;
  logic [7:0]    bank [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s    = scl_ff[SYNC-1];
  assign sda_s    = sda_ff[SYNC-1];
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  assign rd_idx = (state == S_ACKI) ? idx + IW'(1) : idx;

  always_comb begin
    tx_next = 8'hFF;
    if (rd_idx == '0) tx_next = COUNT_BYTE;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i + 1)) tx_next = bank[i];
  end

  assign wr_en = !hold && !start_c && !stop_c && state == S_WDATA && scl_fall && flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank[0] <= FUNC_RST;
      for (int i = 1; i < NREG; i++) bank[i] <= ENA_RST;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++)
        if (idx == IW'(i + 2)) bank[i] <= sh;
    end
  end

  assign func_sel = bank[0];
  for (genvar g = 1; g < NREG; g++) begin : g_out
    assign clk_enables[(g-1)*8 +: 8] = bank[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      flag     <= 1'b0;
      is_read  <= 1'b0;
      sh       <= '0;
      txsh     <= '1;
      idx      <= '0;
      sda_pull <= 1'b0;
    end else if (hold) begin
      state    <= S_IDLE;
      bitcnt   <= '0;
      flag     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      state    <= S_ADDR;
      bitcnt   <= '0;
      flag     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      flag     <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) flag <= 1'b1;
          end else if (scl_fall && flag) begin
            flag   <= 1'b0;
            bitcnt <= '0;
            if (state == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                is_read  <= sh[0];
                idx      <= '0;
                sda_pull <= 1'b1;
                state    <= S_ACKO;
              end else begin
                state <= S_WAIT;
              end
            end else begin
              if (idx != IDX_CAP) idx <= idx + IW'(1);
              sda_pull <= 1'b1;
              state    <= S_ACKO;
            end
          end
        end
        S_ACKO: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (is_read) begin
              txsh     <= tx_next;
              sda_pull <= ~tx_next[7];
              state    <= S_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_WDATA;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) flag <= 1'b1;
          end else if (scl_fall) begin
            if (flag) begin
              flag     <= 1'b0;
              bitcnt   <= '0;
              sda_pull <= 1'b0;
              state    <= S_ACKI;
            end else begin
              sda_pull <= ~txsh[6];
              txsh     <= {txsh[6:0], 1'b1};
            end
          end
        end
        S_ACKI: begin
          if (scl_rise) begin
            flag <= ~sda_s;
          end else if (scl_fall) begin
            flag   <= 1'b0;
            bitcnt <= '0;
            if (flag && idx < IDX_LAST) begin
              idx      <= idx + IW'(1);
              txsh     <= tx_next;
              sda_pull <= ~tx_next[7];
              state    <= S_TX;
            end else begin
              sda_pull <= 1'b0;
              state    <= S_WAIT;
            end
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk #(
  parameter int NREG = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  hold,
  input logic                  scl_s,
  input logic                  sda_pull,
  input logic [7:0]            func_sel,
  input logic [(NREG-1)*8-1:0] clk_enables
);

  logic [NREG*8-1:0] all_regs, prev_regs;
  logic [NREG-1:0]   byte_diff;

  assign all_regs = {clk_enables, func_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_regs <= all_regs;
    else        prev_regs <= all_regs;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_diff
    assign byte_diff[g] = all_regs[g*8 +: 8] != prev_regs[g*8 +: 8];
  end

  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> (!$past(scl_s) || $past(hold)));

  a_r3_update_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(all_regs) |-> !$past(scl_s));

  a_r3_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(byte_diff) <= 1);

  a_r8_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !sda_pull);

  a_r8_hold_retain: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(all_regs));

endmodule

bind cfgbus_slave cfgbus_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .scl_s(scl_s), .sda_pull(sda_pull),
  .func_sel(func_sel), .clk_enables(clk_enables)
);

// File: tb/test_cfgbus_slave.sv
module test_cfgbus_slave;
  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pull, sda_line;
  logic [7:0] func_sel;
  logic [(NREG-1)*8-1:0] clk_enables;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  cfgbus_slave i_cfgbus_slave (
    .clk(clk), .rst_n(rst_n), .hold(hold), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .func_sel(func_sel), .clk_enables(clk_enables)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [7:0] rx_val;
  event       rx_ev;
  logic [7:0] mdl [NREG];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(rx_ev);
      if (exp_v.size() == 0) begin
        check(1'b0, "unexpected read byte", 64'(rx_val), 64'hx);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_tag.pop_front();
        check(rx_val === e, t, 64'(rx_val), 64'(e));
      end
    end
  end

  task automatic push_exp(input logic [7:0] v, input string t);
    exp_v.push_back(v);
    exp_tag.push_back(t);
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wq(Q);
    scl = 1'b1; wq(Q);
    r = sda_line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(input logic do_ack);
    logic r;
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      b[i] = r;
    end
    bit_io(!do_ack, r);
    rx_val = b;
    ->rx_ev;
  endtask

  function automatic logic [7:0] port_reg(input int k);
    return (k == 0) ? func_sel : clk_enables[(k-1)*8 +: 8];
  endfunction

  task automatic check_bank(input string tag);
    for (int k = 0; k < NREG; k++)
      check(port_reg(k) === mdl[k], tag, 64'(port_reg(k)), 64'(mdl[k]));
  endtask

  task automatic write_frame(input int n, input logic [7:0] base, input bit exp_ack, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    check(a == exp_ack, {tag, " address ack"}, 64'(a), 64'(exp_ack));
    send_byte(8'h5A, a);
    check(a == exp_ack, {tag, " R2 command ack"}, 64'(a), 64'(exp_ack));
    send_byte(8'h03, a);
    check(a == exp_ack, {tag, " R2 count ack"}, 64'(a), 64'(exp_ack));
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i * 17), a);
      check(a == exp_ack, {tag, " data ack"}, 64'(a), 64'(exp_ack));
      if (exp_ack && i < NREG) mdl[i] = base + 8'(i * 17);
    end
    bus_stop();
  endtask

  task automatic read_frame(input int n_ack, input int n_total, input string tag);
    logic a;
    bus_start();
    send_byte(8'hD3, a);
    check(a, {tag, " R1 read address ack"}, 64'(a), 64'd1);
    for (int i = 0; i < n_total; i++) begin
      if (i == 0) push_exp(8'(NREG), {tag, " count byte"});
      else if (i <= n_ack && i <= NREG) push_exp(mdl[i-1], {tag, " register byte"});
      else push_exp(8'hFF, {tag, " R6 released SDA"});
      recv_byte(i < n_ack);
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic a, r;
    mdl[0] = 8'h0C;
    for (int k = 1; k < NREG; k++) mdl[k] = 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    check_bank("R7 reset value");
    check(sda_pull == 1'b0, "R7 SDA released at reset", 64'(sda_pull), 64'd0);

    bus_start();
    send_byte(8'hD2, a);
    check(a, "R1 write address ack", 64'(a), 64'd1);
    send_byte(8'h00, a);
    check(a, "R2 command ack", 64'(a), 64'd1);
    send_byte(8'h01, a);
    check(a, "R2 count ack", 64'(a), 64'd1);
    check(sda_pull == 1'b0, "R10 SDA released after ack", 64'(sda_pull), 64'd0);
    check_bank("R2 placeholders ignored");
    send_byte(8'hA1, a);
    check(a, "R3 data ack", 64'(a), 64'd1);
    mdl[0] = 8'hA1;
    check(func_sel === 8'hA1, "R3 register 0 loaded before STOP", 64'(func_sel), 64'hA1);
    for (int i = 1; i < NREG; i++) begin
      send_byte(8'h10 + 8'(i), a);
      check(a, "R3 data ack", 64'(a), 64'd1);
      mdl[i] = 8'h10 + 8'(i);
    end
    bus_stop();
    check_bank("R3 full write");

    bus_start();
    send_byte(8'hA4, a);
    check(!a, "R1 foreign address not acked", 64'(a), 64'd0);
    send_byte(8'h77, a);
    check(!a, "R1 ignored after foreign address", 64'(a), 64'd0);
    bus_stop();
    check_bank("R1 bank untouched by foreign frame");

    write_frame(2, 8'h30, 1'b1, "R4 partial write");
    check_bank("R4 partial write keeps rest");

    write_frame(8, 8'h40, 1'b1, "R9 overlong write");
    check_bank("R9 extra bytes discarded");

    read_frame(NREG, NREG + 1, "R5 full read");
    read_frame(NREG + 1, NREG + 2, "R6 read past last register");
    read_frame(1, 3, "R6 early NACK");

    hold = 1'b1;
    wq(4);
    write_frame(3, 8'h90, 1'b0, "R8 hold frame");
    check_bank("R8 registers retained during hold");
    hold = 1'b0;
    wq(4);

    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    for (int i = 7; i >= 1; i--) bit_io(1'b0, r);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; hold = 1'b1; wq(Q);
    bit_io(1'b1, r);
    check(r == 1'b1, "R8 no ack when hold meets byte end", 64'(r), 64'd1);
    check_bank("R8 hold wins over same-cycle update");
    hold = 1'b0;
    bus_stop();

    read_frame(NREG, NREG + 1, "R8 readback after hold");

    wq(10);
    check(exp_v.size() == 0, "scoreboard drained", 64'(exp_v.size()), 64'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule